// File: doc/BRIEF.md
# Debug Run-Control Register Block

This block is the register face of a processor's halting debug logic. A debugger reaches it over a plain 32-bit read/write bus addressed by word offset. The registers let the debugger ask the core to stop, resume, or drop its pending memory traffic. They report whether the core sits in debug state and why it entered. They latch exception and data-channel events so that short pulses are not missed, and they hold a vector-catch mask that goes out to the core.

All writes except the lock key are refused until a fixed 32-bit key has unlocked the block. Reads are never refused. Event flags follow three clearing rules. Some clear when they are read. Some clear when a run-control command is written. The live level bits simply follow their inputs. Run-control commands reach the core as single-cycle request pulses.

Top module: `dbg_runctl_regs`

## Requirements
- R1: After reset the block is locked, so offset 5 reads 0x7. The status word reads 0x2, which is only the restarted flag, assuming the core is not halted. The vector-catch register reads 0 and no request pulse is active.
- R2: While locked, writes to offsets 0, 1 and 2 have no effect and reads still return data. Writing 0xC5ACCE55 to offset 4 unlocks the block, and offset 5 then reads 0x5. Writing any other value to offset 4 locks it again. Offset 5 reads bit 0 = 1 (lock present), bit 1 = locked and bit 2 = 1 (32-bit access).
- R3: Status bit 31 is set by a receive-fill pulse and bit 30 by a transmit-fill pulse. Each clears after a read of offset 0. A fill pulse in the same cycle as the read keeps the bit set.
- R4: Status bit 25 is set by an instruction-executed pulse. It is cleared by writing offset 1 with bit 3 = 1. A pulse in the same cycle as the clear wins.
- R5: Status bits 8, 7 and 6 latch the undefined, asynchronous-abort and synchronous-abort pulses respectively. A read does not clear them. Writing offset 1 with bit 2 = 1 clears all three.
- R6: Writing offset 1 with bit 0, bit 1 or bit 4 set raises `halt_req_o`, `restart_req_o` or `cancel_req_o` for exactly the next cycle. Offset 1 reads 0.
- R7: Status bit 0 follows `core_halted_i`. Bits 5:2 capture `core_entry_i` when `core_halted_i` rises, using the codes 0 halt request, 1 breakpoint, 3 breakpoint instruction, 4 external request and 10 watchpoint. That value holds until the next rise.
- R8: Status bit 1 (restarted) is 1 after reset. It clears on a restart request or on entry to debug state, and it is set by a `core_restarted_i` pulse.
- R9: Status bits 21:20 hold the data-channel mode, with 0 non-blocking, 1 stall and 2 fast. A write of 3 leaves the mode unchanged. Bits 15:10 are six writable control bits. All other status bits ignore writes.
- R10: Offset 2 stores only bits 0 to 4, 6 and 7 of a write. Bit 5 and bits 31:8 read 0. The stored value drives `vcatch_o`.
- R11: Offset 3 reads live reset at bit 2, live power-down at bit 0, sticky reset at bit 3 and sticky power-down at bit 1. A sticky bit is set while its level is high and clears on a read of offset 3 once the level is low. Other bits read 0, and writes to offset 3 have no effect.
- R12: Offset 4 and unmapped offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| core_halted_i | input | 1 | Core is in debug state |
| core_entry_i | input | 4 | Reason code for debug entry |
| core_restarted_i | input | 1 | Pulse: core has left debug state |
| core_instr_i | input | 1 | Pulse: instruction executed |
| core_und_i | input | 1 | Pulse: undefined instruction |
| core_async_abt_i | input | 1 | Pulse: asynchronous abort |
| core_sync_abt_i | input | 1 | Pulse: synchronous abort |
| core_rx_fill_i | input | 1 | Pulse: receive channel filled |
| core_tx_fill_i | input | 1 | Pulse: transmit channel filled |
| core_in_reset_i | input | 1 | Core is in reset |
| core_pwr_down_i | input | 1 | Core is powered down |
| halt_req_o | output | 1 | One-cycle halt request |
| restart_req_o | output | 1 | One-cycle restart request |
| cancel_req_o | output | 1 | One-cycle cancel of memory requests |
| vcatch_o | output | 8 | Vector-catch enables |

## Verification
The bench targets the collisions between setting and clearing. A fill pulse that lands on the reading cycle must survive, or a design that lets the clear win loses data. An instruction pulse that lands on the pipeline-advance clear must also survive. A design that clears sticky abort flags on read, or leaves them set after the clear command, shows up in repeated reads of offset 0. The lock tests write a wrong key after a good one and confirm that writes stop again, which catches a lock that only ever opens. The entry-method capture is checked by changing the code while the core stays halted, which exposes a design that samples continuously instead of on the rising edge.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    // Word offsets
    localparam logic [ADDR_W-1:0] OFS_STATUS  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_RUNCTL  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_VCATCH  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_PWRST   = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFS_LOCKKEY = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_LOCKST  = ADDR_W'(5);

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;

    // Run-control command bits
    localparam int RC_HALT    = 0;
    localparam int RC_RESTART = 1;
    localparam int RC_CLREXC  = 2;
    localparam int RC_CLRPIPE = 3;
    localparam int RC_CANCEL  = 4;

    // Status bit positions
    localparam int ST_RXFULL  = 31;
    localparam int ST_TXFULL  = 30;
    localparam int ST_PIPEADV = 25;
    localparam int ST_MODE_LO = 20;
    localparam int ST_CTL_LO  = 10;
    localparam int ST_UND     = 8;
    localparam int ST_AABT    = 7;
    localparam int ST_SABT    = 6;
    localparam int ST_ENTRY_LO = 2;
    localparam int ST_RESTART = 1;
    localparam int ST_HALTED  = 0;

    localparam int CTL_W   = 6;
    localparam int ENTRY_W = 4;
    localparam int VC_W    = 8;
    localparam logic [VC_W-1:0] VCATCH_MASK_DEF = 8'hDF;
    localparam int NUM_REQ = 3;

    typedef enum logic [1:0] {
        XFER_NONBLOCK = 2'd0,
        XFER_STALL    = 2'd1,
        XFER_FAST     = 2'd2,
        XFER_RSVD     = 2'd3
    } xfer_mode_e;

    typedef enum logic [ENTRY_W-1:0] {
        ENTRY_HALTREQ   = 4'd0,
        ENTRY_BKPT      = 4'd1,
        ENTRY_BKPT_INSN = 4'd3,
        ENTRY_EXTERNAL  = 4'd4,
        ENTRY_WATCH     = 4'd10
    } entry_code_e;

    typedef struct packed {
        logic rd_status;
        logic rd_pwr;
        logic wr_status;
        logic wr_runctl;
        logic wr_vcatch;
        logic wr_lock;
    } access_t;

    typedef struct packed {
        logic       rx_full;
        logic       tx_full;
        logic       pipe_adv;
        xfer_mode_e mode;
        logic [CTL_W-1:0] ctl;
        logic [2:0] exc;       // {und, async, sync}
        logic [ENTRY_W-1:0] entry;
        logic       restarted;
        logic       halted;
    } status_t;

    function automatic access_t decode_access(
        input logic sel, input logic wr, input logic [ADDR_W-1:0] addr);
        access_t a;
        a.rd_status = sel && !wr && (addr == OFS_STATUS);
        a.rd_pwr    = sel && !wr && (addr == OFS_PWRST);
        a.wr_status = sel && wr && (addr == OFS_STATUS);
        a.wr_runctl = sel && wr && (addr == OFS_RUNCTL);
        a.wr_vcatch = sel && wr && (addr == OFS_VCATCH);
        a.wr_lock   = sel && wr && (addr == OFS_LOCKKEY);
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input status_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_RXFULL]  = s.rx_full;
        w[ST_TXFULL]  = s.tx_full;
        w[ST_PIPEADV] = s.pipe_adv;
        w[ST_MODE_LO +: 2] = s.mode;
        w[ST_CTL_LO +: CTL_W] = s.ctl;
        w[ST_UND]  = s.exc[2];
        w[ST_AABT] = s.exc[1];
        w[ST_SABT] = s.exc[0];
        w[ST_ENTRY_LO +: ENTRY_W] = s.entry;
        w[ST_RESTART] = s.restarted;
        w[ST_HALTED]  = s.halted;
        return w;
    endfunction

endpackage

// File: rtl/dbg_lock_gate.sv
module dbg_lock_gate
    import dbg_runctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output access_t           acc_o,
    output logic              locked_o
);
    access_t raw;
    logic    locked_q;

    always_comb begin
        raw = decode_access(bus_sel, bus_wr, bus_addr);
        acc_o = raw;
        acc_o.wr_status = raw.wr_status && !locked_q;
        acc_o.wr_runctl = raw.wr_runctl && !locked_q;
        acc_o.wr_vcatch = raw.wr_vcatch && !locked_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            locked_q <= 1'b1;
        else if (raw.wr_lock)
            locked_q <= (bus_wdata != UNLOCK_KEY);
    end

    assign locked_o = locked_q;
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
    import dbg_runctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [1:0]         wr_mode_i,
    input  logic [CTL_W-1:0]   wr_ctl_i,
    input  logic               clr_exc_i,
    input  logic               clr_pipe_i,
    input  logic               restart_cmd_i,
    input  logic               core_halted_i,
    input  logic [ENTRY_W-1:0] core_entry_i,
    input  logic               core_restarted_i,
    input  logic               core_instr_i,
    input  logic [2:0]         exc_set_i,
    input  logic               rx_fill_i,
    input  logic               tx_fill_i,
    output logic [DATA_W-1:0]  status_o
);
    status_t s_q;
    logic    halted_prev_q;
    logic    halt_rise;

    assign halt_rise = core_halted_i && !halted_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.rx_full   <= 1'b0;
            s_q.tx_full   <= 1'b0;
            s_q.pipe_adv  <= 1'b0;
            s_q.mode      <= XFER_NONBLOCK;
            s_q.ctl       <= '0;
            s_q.exc       <= '0;
            s_q.entry     <= '0;
            s_q.restarted <= 1'b1;
            s_q.halted    <= 1'b0;
            halted_prev_q <= 1'b0;
        end else begin
            halted_prev_q <= core_halted_i;
            s_q.halted    <= 1'b0;
            s_q.rx_full   <= rx_fill_i || (s_q.rx_full && !rd_i);
            s_q.tx_full   <= tx_fill_i || (s_q.tx_full && !rd_i);
            s_q.pipe_adv  <= core_instr_i || (s_q.pipe_adv && !clr_pipe_i);
            s_q.exc       <= exc_set_i | (s_q.exc & {3{!clr_exc_i}});
            if (wr_i) begin
                s_q.ctl <= wr_ctl_i;
                if (xfer_mode_e'(wr_mode_i) != XFER_RSVD)
                    s_q.mode <= xfer_mode_e'(wr_mode_i);
            end
            if (halt_rise)
                s_q.entry <= core_entry_i;
            if (core_restarted_i)
                s_q.restarted <= 1'b1;
            else if (halt_rise || restart_cmd_i)
                s_q.restarted <= 1'b0;
        end
    end

    always_comb begin
        status_t view;
        view = s_q;
        view.halted = core_halted_i;
        status_o = pack_status(view);
    end
endmodule

// File: rtl/dbg_pwr_status.sv
module dbg_pwr_status
    import dbg_runctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic              in_reset_i,
    input  logic              pwr_down_i,
    output logic [DATA_W-1:0] word_o
);
    logic sticky_rst_q;
    logic sticky_pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_rst_q <= 1'b0;
            sticky_pd_q  <= 1'b0;
        end else begin
            sticky_rst_q <= in_reset_i || (sticky_rst_q && !rd_i);
            sticky_pd_q  <= pwr_down_i || (sticky_pd_q && !rd_i);
        end
    end

    assign word_o = {{(DATA_W-4){1'b0}}, sticky_rst_q, in_reset_i, sticky_pd_q, pwr_down_i};
endmodule

// File: rtl/dbg_req_pulse.sv
module dbg_req_pulse #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] fire_i,
    output logic [NUM-1:0] pulse_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_req
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= fire_i[g];
        end
        assign pulse_o[g] = q;
    end
endmodule

// File: rtl/dbg_runctl_regs.sv
module dbg_runctl_regs
    import dbg_runctl_pkg::*;
#(
    parameter logic [VC_W-1:0] VCATCH_MASK = VCATCH_MASK_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               core_halted_i,
    input  logic [ENTRY_W-1:0] core_entry_i,
    input  logic               core_restarted_i,
    input  logic               core_instr_i,
    input  logic               core_und_i,
    input  logic               core_async_abt_i,
    input  logic               core_sync_abt_i,
    input  logic               core_rx_fill_i,
    input  logic               core_tx_fill_i,
    input  logic               core_in_reset_i,
    input  logic               core_pwr_down_i,
    output logic               halt_req_o,
    output logic               restart_req_o,
    output logic               cancel_req_o,
    output logic [VC_W-1:0]    vcatch_o
);
    access_t           acc;
    logic              locked;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] pwr_word;
    logic [VC_W-1:0]   vcatch_q;
    logic [NUM_REQ-1:0] req_fire;
    logic [NUM_REQ-1:0] req_pulse;

    dbg_lock_gate u_lock (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .acc_o(acc), .locked_o(locked)
    );

    dbg_status_reg u_status (
        .clk(clk), .rst(rst),
        .rd_i(acc.rd_status),
        .wr_i(acc.wr_status),
        .wr_mode_i(bus_wdata[ST_MODE_LO +: 2]),
        .wr_ctl_i(bus_wdata[ST_CTL_LO +: CTL_W]),
        .clr_exc_i(acc.wr_runctl && bus_wdata[RC_CLREXC]),
        .clr_pipe_i(acc.wr_runctl && bus_wdata[RC_CLRPIPE]),
        .restart_cmd_i(acc.wr_runctl && bus_wdata[RC_RESTART]),
        .core_halted_i(core_halted_i),
        .core_entry_i(core_entry_i),
        .core_restarted_i(core_restarted_i),
        .core_instr_i(core_instr_i),
        .exc_set_i({core_und_i, core_async_abt_i, core_sync_abt_i}),
        .rx_fill_i(core_rx_fill_i),
        .tx_fill_i(core_tx_fill_i),
        .status_o(status_word)
    );

    dbg_pwr_status u_pwr (
        .clk(clk), .rst(rst),
        .rd_i(acc.rd_pwr),
        .in_reset_i(core_in_reset_i),
        .pwr_down_i(core_pwr_down_i),
        .word_o(pwr_word)
    );

    assign req_fire = {NUM_REQ{acc.wr_runctl}} &
                      {bus_wdata[RC_CANCEL], bus_wdata[RC_RESTART], bus_wdata[RC_HALT]};

    dbg_req_pulse #(.NUM(NUM_REQ)) u_req (
        .clk(clk), .rst(rst), .fire_i(req_fire), .pulse_o(req_pulse)
    );

    assign halt_req_o    = req_pulse[0];
    assign restart_req_o = req_pulse[1];
    assign cancel_req_o  = req_pulse[2];

    always_ff @(posedge clk) begin
        if (rst)
            vcatch_q <= '0;
        else if (acc.wr_vcatch)
            vcatch_q <= bus_wdata[VC_W-1:0] & VCATCH_MASK;
    end
    assign vcatch_o = vcatch_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_STATUS: bus_rdata = status_word;
                OFS_VCATCH: bus_rdata = {{(DATA_W-VC_W){1'b0}}, vcatch_q};
                OFS_PWRST:  bus_rdata = pwr_word;
                OFS_LOCKST: bus_rdata = {{(DATA_W-3){1'b0}}, 1'b1, locked, 1'b1};
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk
    import dbg_runctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [4:0]        cmd_bits,
    input logic              halt_req_o,
    input logic              restart_req_o,
    input logic              cancel_req_o,
    input logic              core_instr_i,
    input logic              core_rx_fill_i,
    input logic              core_in_reset_i,
    input logic              locked,
    input logic              st_rx,
    input logic              st_pipe,
    input logic              st_und,
    input logic              pwr_srst
);
    logic runctl_wr;
    assign runctl_wr = bus_sel && bus_wr && (bus_addr == OFS_RUNCTL) && !locked;

    // R6: a halt pulse only follows an accepted halt command
    a_r6_halt_from_write: assert property (@(posedge clk) disable iff (rst)
        halt_req_o |-> $past(runctl_wr && cmd_bits[RC_HALT]));

    // R6: a cancel pulse only follows an accepted cancel command
    a_r6_cancel_from_write: assert property (@(posedge clk) disable iff (rst)
        cancel_req_o |-> $past(runctl_wr && cmd_bits[RC_CANCEL]));

    // R2: no restart pulse can come from a write made while locked
    a_r2_restart_unlocked: assert property (@(posedge clk) disable iff (rst)
        restart_req_o |-> $past(!locked));

    // R4: an executed instruction always sets pipeline-advance
    a_r4_pipe_sets: assert property (@(posedge clk) disable iff (rst)
        core_instr_i |=> st_pipe);

    // R5: the undefined flag holds unless the clear command is accepted
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (st_und && !(runctl_wr && cmd_bits[RC_CLREXC])) |=> st_und);

    // R3: a status read with no new fill clears receive-full
    a_r3_rx_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == OFS_STATUS && !core_rx_fill_i) |=> !st_rx);

    // R11: core reset always leaves the sticky reset bit set
    a_r11_sticky_rst: assert property (@(posedge clk) disable iff (rst)
        core_in_reset_i |=> pwr_srst);
endmodule

bind dbg_runctl_regs dbg_runctl_chk u_chk (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .cmd_bits(bus_wdata[4:0]),
    .halt_req_o(halt_req_o), .restart_req_o(restart_req_o), .cancel_req_o(cancel_req_o),
    .core_instr_i(core_instr_i), .core_rx_fill_i(core_rx_fill_i),
    .core_in_reset_i(core_in_reset_i),
    .locked(locked),
    .st_rx(status_word[31]), .st_pipe(status_word[25]), .st_und(status_word[8]),
    .pwr_srst(pwr_word[3])
);

// File: tb/test_dbg_runctl_regs.sv
module test_dbg_runctl_regs;
    import dbg_runctl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEY = 32'hC5AC_CE55;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_halted_i = 0, core_restarted_i = 0, core_instr_i = 0;
    logic [3:0]  core_entry_i = '0;
    logic        core_und_i = 0, core_async_abt_i = 0, core_sync_abt_i = 0;
    logic        core_rx_fill_i = 0, core_tx_fill_i = 0;
    logic        core_in_reset_i = 0, core_pwr_down_i = 0;
    logic        halt_req_o, restart_req_o, cancel_req_o;
    logic [7:0]  vcatch_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_runctl_regs i_dbg_runctl_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_halted_i(core_halted_i), .core_entry_i(core_entry_i),
        .core_restarted_i(core_restarted_i), .core_instr_i(core_instr_i),
        .core_und_i(core_und_i), .core_async_abt_i(core_async_abt_i),
        .core_sync_abt_i(core_sync_abt_i),
        .core_rx_fill_i(core_rx_fill_i), .core_tx_fill_i(core_tx_fill_i),
        .core_in_reset_i(core_in_reset_i), .core_pwr_down_i(core_pwr_down_i),
        .halt_req_o(halt_req_o), .restart_req_o(restart_req_o),
        .cancel_req_o(cancel_req_o), .vcatch_o(vcatch_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(3'd5, d); check("R1 lock status", d, 32'h7);
        bus_read(3'd0, d); check("R1 status", d, 32'h2);
        bus_read(3'd2, d); check("R1 vcatch", d, 32'h0);
        check("R1 requests", {29'b0, cancel_req_o, restart_req_o, halt_req_o}, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        bus_write(3'd2, 32'hFF);
        bus_read(3'd2, d); check("R2 locked vcatch write ignored", d, 32'h0);
        bus_write(3'd1, 32'h1);
        check("R2 locked halt ignored", {31'b0, halt_req_o}, 32'h0);
        bus_write(3'd4, KEY);
        bus_read(3'd5, d); check("R2 unlocked status", d, 32'h5);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read(3'd2, d); check("R10 vcatch mask", d, 32'hDF);
        check("R10 vcatch_o", {24'b0, vcatch_o}, 32'hDF);
        bus_write(3'd4, KEY ^ 32'h1);
        bus_read(3'd5, d); check("R2 wrong key relocks", d, 32'h7);
        bus_write(3'd2, 32'h0);
        bus_read(3'd2, d); check("R2 relocked write ignored", d, 32'hDF);
        bus_write(3'd4, KEY);
    endtask

    task automatic t_offsets();
        logic [31:0] d;
        bus_read(3'd1, d); check("R6 runctl reads 0", d, 32'h0);
        bus_read(3'd4, d); check("R12 key reads 0", d, 32'h0);
        bus_read(3'd6, d); check("R12 offset 6", d, 32'h0);
        bus_read(3'd7, d); check("R12 offset 7", d, 32'h0);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        bus_write(3'd0, 32'h8010_FC01);
        bus_read(3'd0, d); check("R9 stall mode and ctl", d, 32'h0010_FC02);
        bus_write(3'd0, 32'h0030_0000);
        bus_read(3'd0, d); check("R9 mode 3 ignored", d, 32'h0010_0002);
        bus_write(3'd0, 32'h0020_0000);
        bus_read(3'd0, d); check("R9 fast mode", d, 32'h0020_0002);
        bus_write(3'd0, 32'h0);
        bus_read(3'd0, d); check("R9 nonblocking", d, 32'h0000_0002);
    endtask

    task automatic t_rxtx();
        logic [31:0] d;
        core_rx_fill_i = 1; @(negedge clk); core_rx_fill_i = 0;
        bus_read(3'd0, d); check("R3 rx set", d >> 31, 32'h1);
        bus_read(3'd0, d); check("R3 rx cleared by read", d >> 31, 32'h0);
        core_tx_fill_i = 1; @(negedge clk);
        bus_read(3'd0, d); core_tx_fill_i = 0;
        check("R3 tx set", (d >> 30) & 1, 32'h1);
        bus_read(3'd0, d); check("R3 fill beats read clear", (d >> 30) & 1, 32'h1);
        bus_read(3'd0, d); check("R3 tx cleared", (d >> 30) & 1, 32'h0);
    endtask

    task automatic t_pipe();
        logic [31:0] d;
        core_instr_i = 1; @(negedge clk); core_instr_i = 0;
        bus_read(3'd0, d); check("R4 pipe set", (d >> 25) & 1, 32'h1);
        bus_write(3'd1, 32'h8);
        bus_read(3'd0, d); check("R4 pipe cleared", (d >> 25) & 1, 32'h0);
        core_instr_i = 1; bus_write(3'd1, 32'h8); core_instr_i = 0;
        bus_read(3'd0, d); check("R4 set beats clear", (d >> 25) & 1, 32'h1);
        bus_write(3'd1, 32'h8);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        core_und_i = 1; @(negedge clk); core_und_i = 0;
        core_async_abt_i = 1; @(negedge clk); core_async_abt_i = 0;
        core_sync_abt_i = 1; @(negedge clk); core_sync_abt_i = 0;
        bus_read(3'd0, d); check("R5 all sticky set", (d >> 6) & 7, 32'h7);
        bus_read(3'd0, d); check("R5 read keeps", (d >> 6) & 7, 32'h7);
        bus_write(3'd4, 32'h0);
        bus_write(3'd1, 32'h4);
        bus_read(3'd0, d); check("R2 locked clear ignored", (d >> 6) & 7, 32'h7);
        bus_write(3'd4, KEY);
        bus_write(3'd1, 32'h4);
        bus_read(3'd0, d); check("R5 cleared", (d >> 6) & 7, 32'h0);
    endtask

    task automatic t_halt();
        logic [31:0] d;
        bus_write(3'd1, 32'h1);
        check("R6 halt pulse", {29'b0, cancel_req_o, restart_req_o, halt_req_o}, 32'h1);
        @(negedge clk);
        check("R6 halt one cycle", {31'b0, halt_req_o}, 32'h0);
        core_halted_i = 1; core_entry_i = ENTRY_EXTERNAL; @(negedge clk);
        bus_read(3'd0, d); check("R7 halted entry 4", d, 32'h11);
        core_entry_i = ENTRY_WATCH; @(negedge clk);
        bus_read(3'd0, d); check("R7 entry held", d, 32'h11);
        bus_write(3'd1, 32'h2);
        check("R6 restart pulse", {29'b0, cancel_req_o, restart_req_o, halt_req_o}, 32'h2);
        core_halted_i = 0; core_restarted_i = 1; @(negedge clk); core_restarted_i = 0;
        bus_read(3'd0, d); check("R8 restarted set", d, 32'h12);
        core_halted_i = 1; @(negedge clk);
        bus_read(3'd0, d); check("R7 watchpoint entry", d, 32'h29);
        bus_write(3'd1, 32'h2);
        bus_read(3'd0, d); check("R8 cleared by restart", d & 32'h3, 32'h1);
        core_halted_i = 0; core_restarted_i = 1; @(negedge clk); core_restarted_i = 0;
        bus_write(3'd1, 32'h13);
        check("R6 all pulses", {29'b0, cancel_req_o, restart_req_o, halt_req_o}, 32'h7);
        @(negedge clk);
        check("R6 pulses end", {29'b0, cancel_req_o, restart_req_o, halt_req_o}, 32'h0);
        bus_write(3'd1, 32'h10);
        check("R6 cancel alone", {29'b0, cancel_req_o, restart_req_o, halt_req_o}, 32'h4);
    endtask

    task automatic t_pwr();
        logic [31:0] d;
        core_in_reset_i = 1; @(negedge clk); core_in_reset_i = 0;
        bus_read(3'd3, d); check("R11 sticky reset", d, 32'h8);
        bus_read(3'd3, d); check("R11 sticky reset cleared", d, 32'h0);
        core_pwr_down_i = 1; @(negedge clk);
        bus_read(3'd3, d); check("R11 power down live", d, 32'h3);
        bus_read(3'd3, d); check("R11 sticky held by level", d, 32'h3);
        core_pwr_down_i = 0; @(negedge clk);
        bus_read(3'd3, d); check("R11 sticky after level low", d, 32'h2);
        bus_read(3'd3, d); check("R11 cleared", d, 32'h0);
        bus_write(3'd3, 32'hFFFF_FFFF);
        bus_read(3'd3, d); check("R11 write ignored", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_lock();
        t_offsets();
        t_mode();
        t_rxtx();
        t_pipe();
        t_sticky();
        t_halt();
        t_pwr();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule